// File: doc/BRIEF.md
# Multi-Domain Clock-Enable Divider

This block turns one fast reference clock into a set of periodic single-cycle enable pulses, one for each of seven clock domains: CPU, AHB, APB, LCD device, memory, USB and LCD pixel. Logic in each domain runs on the reference clock and advances only in the cycles where its enable is high. The outputs are enables, never gated clocks, so every consumer stays on one clock tree.

A 32-bit control word holds one divider code for each domain. The five core domains (CPU, AHB, APB, LCD device, memory) take a 4-bit code that selects a ratio from a non-linear list. The USB domain takes a 3-bit code with ratio code+1, or it follows an external 48 MHz enable when its source-select bit is set. A separate 9-bit word sets the pixel ratio to code+1. When the PLL-enable input is low, the five core domains run undivided and enable every cycle. The USB and pixel domains keep dividing.

A code change is picked up only when the running period ends. Because of this, no pulse interval ever mixes the old and new ratios.

Top module: `domain_clk_div`

## Requirements
- R1: A 4-bit core code c of 0..9 selects the ratio 1, 2, 3, 4, 6, 8, 12, 16, 24 or 32 (entry c of that list).
- R2: The core codes are read from ctrl_word as follows: CPU bits 3..0, AHB bits 7..4, APB bits 11..8, LCD device bits 15..12, memory bits 19..16.
- R3: Core codes 10 to 15 give a ratio of 32.
- R4: With ctrl_word bit 28 clear, usb_en divides by ctrl_word[27:25]+1. This holds whatever the state of pll_on.
- R5: With ctrl_word bit 28 set, usb_en equals usb48_en in the same cycle. This holds during reset as well.
- R6: pix_en divides by pix_word+1 (1..512) whatever the state of pll_on.
- R7: In every cycle after an edge that sees pll_on low (outside reset), the five core enables are high. Counting restarts from zero at the first edge that sees pll_on high again.
- R8: A divider copies its code only at reset, during PLL bypass, or at its own terminal count. Until then the running period keeps the old ratio.
- R9: While rst is high at an edge, all divided outputs are low afterwards and the counters clear. With ratio N, the first pulse appears after the N-th edge that sees rst low.
- R10: Each divided enable is high for exactly one reference cycle and repeats every N cycles. For N=1 it is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_on | input | 1 | High: core domains divide; low: core domains enable every cycle |
| ctrl_word | input | 32 | Divider codes for core and USB domains, USB source select in bit 28 |
| pix_word | input | 9 | Pixel divider code, ratio code+1 |
| usb48_en | input | 1 | External 48 MHz enable, used when bit 28 is set |
| cpu_en | output | 1 | CPU domain enable |
| ahb_en | output | 1 | AHB domain enable |
| apb_en | output | 1 | APB domain enable |
| lcd_en | output | 1 | LCD device domain enable |
| mem_en | output | 1 | Memory domain enable |
| usb_en | output | 1 | USB domain enable |
| pix_en | output | 1 | LCD pixel domain enable |

## Verification
The first pattern gives the five core fields five different codes. Any swap of field positions or table entries then shows up as a wrong pulse spacing. A second pattern fills the fields with the codes 10..15, which separates a divide-by-32 clamp from a wrapped or truncated table lookup. Codes are also rewritten in the middle of a period, so a design that reloads at once can be told apart from one that waits for the terminal count. Further patterns toggle pll_on, toggle the USB source select and run the largest pixel ratio. These show that bypass reaches only the core domains and that the pixel and USB dividers keep their own counts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CORE_DOMAINS  = 5;
    localparam int CORE_CODE_W   = 4;
    localparam int CORE_RATIO_W  = 6;
    localparam int USB_CODE_W    = 3;
    localparam int USB_RATIO_W   = USB_CODE_W + 1;
    localparam int PIX_CODE_W    = 9;
    localparam int PIX_RATIO_W   = PIX_CODE_W + 1;
    localparam int USB_CODE_LSB  = 25;
    localparam int USB_SEL_BIT   = 28;

    function automatic logic [CORE_RATIO_W-1:0] core_ratio(input logic [CORE_CODE_W-1:0] code);
        logic [CORE_RATIO_W-1:0] r;
        case (code)
            4'd0:    r = 6'd1;
            4'd1:    r = 6'd2;
            4'd2:    r = 6'd3;
            4'd3:    r = 6'd4;
            4'd4:    r = 6'd6;
            4'd5:    r = 6'd8;
            4'd6:    r = 6'd12;
            4'd7:    r = 6'd16;
            4'd8:    r = 6'd24;
            default: r = 6'd32;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/code_map.sv
module code_map #(
    parameter int CODE_W  = 4,
    parameter int RATIO_W = 6,
    parameter bit TABLE   = 1'b1
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio
);
    import clkdiv_pkg::*;

    generate
        if (TABLE) begin : g_table
            always_comb begin
                ratio = RATIO_W'(core_ratio(CORE_CODE_W'(code)));
            end
        end else begin : g_linear
            always_comb begin
                ratio = RATIO_W'(code) + RATIO_W'(1);
            end
        end
    endgenerate

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass,
    input  logic [CNT_W-1:0] ratio_in,
    output logic             en_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ratio;
        logic             en;
    } div_state_t;

    div_state_t s_d, s_q;
    logic       tc;

    always_comb begin
        s_d = s_q;
        tc  = (s_q.cnt == (s_q.ratio - ONE));
        if (rst) begin
            s_d.cnt   = '0;
            s_d.ratio = ratio_in;
            s_d.en    = 1'b0;
        end else if (bypass || tc) begin
            s_d.cnt   = '0;
            s_d.ratio = ratio_in;
            s_d.en    = 1'b1;
        end else begin
            s_d.cnt   = s_q.cnt + ONE;
            s_d.en    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign en_o = s_q.en;

    // R7: bypass forces an enable in the following cycle
    a_r7_bypass_high: assert property (@(posedge clk) disable iff (rst)
        bypass |=> s_q.en);

    // R8: ratio is held while a period is running
    a_r8_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tc) |=> $stable(s_q.ratio));

    // R9: counter never reaches its ratio
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt < s_q.ratio);

    // R10: a pulse is one cycle wide unless the ratio is one
    a_r10_one_wide: assert property (@(posedge clk) disable iff (rst)
        (s_q.en && !bypass && s_q.ratio != ONE) |=> !s_q.en);

endmodule

// File: rtl/domain_clk_div.sv
module domain_clk_div
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pll_on,
    input  logic [31:0] ctrl_word,
    input  logic [8:0]  pix_word,
    input  logic        usb48_en,
    output logic        cpu_en,
    output logic        ahb_en,
    output logic        apb_en,
    output logic        lcd_en,
    output logic        mem_en,
    output logic        usb_en,
    output logic        pix_en
);
    logic [CORE_DOMAINS-1:0] core_en;
    logic                    usb_div_en;
    logic [USB_RATIO_W-1:0]  usb_ratio;
    logic [PIX_RATIO_W-1:0]  pix_ratio;
    logic                    unused_ctrl;

    assign unused_ctrl = ^{ctrl_word[31:29], ctrl_word[24:20]};

    genvar g;
    generate
        for (g = 0; g < CORE_DOMAINS; g++) begin : g_core
            logic [CORE_RATIO_W-1:0] ratio;
            code_map #(.CODE_W(CORE_CODE_W), .RATIO_W(CORE_RATIO_W), .TABLE(1'b1)) u_map (
                .code  (ctrl_word[CORE_CODE_W*g +: CORE_CODE_W]),
                .ratio (ratio)
            );
            div_core #(.CNT_W(CORE_RATIO_W)) u_div (
                .clk      (clk),
                .rst      (rst),
                .bypass   (~pll_on),
                .ratio_in (ratio),
                .en_o     (core_en[g])
            );
        end
    endgenerate

    code_map #(.CODE_W(USB_CODE_W), .RATIO_W(USB_RATIO_W), .TABLE(1'b0)) u_usb_map (
        .code  (ctrl_word[USB_CODE_LSB +: USB_CODE_W]),
        .ratio (usb_ratio)
    );
    div_core #(.CNT_W(USB_RATIO_W)) u_usb_div (
        .clk      (clk),
        .rst      (rst),
        .bypass   (1'b0),
        .ratio_in (usb_ratio),
        .en_o     (usb_div_en)
    );

    code_map #(.CODE_W(PIX_CODE_W), .RATIO_W(PIX_RATIO_W), .TABLE(1'b0)) u_pix_map (
        .code  (pix_word),
        .ratio (pix_ratio)
    );
    div_core #(.CNT_W(PIX_RATIO_W)) u_pix_div (
        .clk      (clk),
        .rst      (rst),
        .bypass   (1'b0),
        .ratio_in (pix_ratio),
        .en_o     (pix_en)
    );

    assign cpu_en = core_en[0];
    assign ahb_en = core_en[1];
    assign apb_en = core_en[2];
    assign lcd_en = core_en[3];
    assign mem_en = core_en[4];
    assign usb_en = ctrl_word[USB_SEL_BIT] ? usb48_en : usb_div_en;

endmodule

// File: tb/domain_clk_div_bench.sv
module domain_clk_div_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        pll_on;
    logic [31:0] ctrl_word;
    logic [8:0]  pix_word;
    logic        usb48_en;
    logic        cpu_en, ahb_en, apb_en, lcd_en, mem_en, usb_en, pix_en;

    always #2 clk = ~clk;

    domain_clk_div u_domain_clk_div (
        .clk(clk), .rst(rst), .pll_on(pll_on), .ctrl_word(ctrl_word),
        .pix_word(pix_word), .usb48_en(usb48_en),
        .cpu_en(cpu_en), .ahb_en(ahb_en), .apb_en(apb_en), .lcd_en(lcd_en),
        .mem_en(mem_en), .usb_en(usb_en), .pix_en(pix_en)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R9";
    int    per [7];
    int    cnt [7];
    bit    ex  [7];

    function automatic int table_ratio(int c);
        case (c)
            0: return 1;  1: return 2;  2: return 3;  3: return 4;
            4: return 6;  5: return 8;  6: return 12; 7: return 16;
            8: return 24; default: return 32;
        endcase
    endfunction

    function automatic int want(int i);
        if (i < 5) return table_ratio(int'(ctrl_word[4*i +: 4]));
        if (i == 5) return int'(ctrl_word[27:25]) + 1;
        return int'(pix_word) + 1;
    endfunction

    // reference model, updated at each rising edge from pre-edge inputs
    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < 7; i++) begin
            if (rst) begin
                cnt[i] = 0; per[i] = want(i); ex[i] = 0;
            end else if (i < 5 && !pll_on) begin
                cnt[i] = 0; per[i] = want(i); ex[i] = 1;
            end else if (cnt[i] == per[i] - 1) begin
                cnt[i] = 0; per[i] = want(i); ex[i] = 1;
            end else begin
                cnt[i]++; ex[i] = 0;
            end
        end
        if (cycles > 50000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish (got %0d cycles, exp below 50000)", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic cmp(string name, logic got, bit expv);
        compared++;
        if (got !== expv) begin
            mismatched++;
            $display("FAIL %s %s got %0b exp %0b at cycle %0d", tag, name, got, expv, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (cycles > 0) begin
            cmp("cpu_en", cpu_en, ex[0]);
            cmp("ahb_en", ahb_en, ex[1]);
            cmp("apb_en", apb_en, ex[2]);
            cmp("lcd_en", lcd_en, ex[3]);
            cmp("mem_en", mem_en, ex[4]);
            cmp("usb_en", usb_en, ctrl_word[28] ? usb48_en : ex[5]);
            cmp("pix_en", pix_en, ex[6]);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] mk(int c0, int c1, int c2, int c3, int c4,
                                      int ucode, bit usel);
        logic [31:0] w = '0;
        w[3:0] = 4'(c0); w[7:4] = 4'(c1); w[11:8] = 4'(c2);
        w[15:12] = 4'(c3); w[19:16] = 4'(c4);
        w[27:25] = 3'(ucode); w[28] = usel;
        return w;
    endfunction

    initial begin
        rst = 1; pll_on = 1; usb48_en = 0; pix_word = 9'd5;
        ctrl_word = mk(0, 1, 2, 4, 9, 3, 0);
        tag = "R9";
        tick(5);
        rst = 0;
        tick(40);
        tag = "R1,R2,R10";
        tick(100);
        // codes above nine clamp
        tag = "R3";
        ctrl_word = mk(10, 15, 12, 11, 13, 3, 0);
        tick(200);
        // mid-period code changes
        tag = "R8";
        for (int k = 0; k < 15; k++) begin
            ctrl_word = mk(k % 10, (k + 3) % 10, (k * 7) % 16, 5, 8 - (k % 8), k % 8, 0);
            pix_word = 9'(k * 3);
            tick(7 + k);
        end
        // USB divider ratios
        tag = "R4";
        ctrl_word = mk(2, 2, 2, 2, 2, 7, 0);
        tick(60);
        ctrl_word = mk(2, 2, 2, 2, 2, 0, 0);
        tick(20);
        // USB external source
        tag = "R5";
        ctrl_word = mk(3, 1, 0, 6, 7, 5, 1);
        for (int k = 0; k < 40; k++) begin
            usb48_en = ((k * 5) % 3) == 0;
            tick(1);
        end
        ctrl_word = mk(3, 1, 0, 6, 7, 5, 0);
        tick(30);
        // PLL bypass: core runs every cycle, USB and pixel keep dividing
        tag = "R7";
        pix_word = 9'd9;
        pll_on = 0;
        tick(40);
        pll_on = 1;
        tick(60);
        tag = "R6";
        pll_on = 0;
        pix_word = 9'd17;
        tick(80);
        pll_on = 1;
        pix_word = 9'd511;
        tick(1100);
        // reset in the middle of a run
        tag = "R9";
        rst = 1;
        ctrl_word[28] = 1;
        usb48_en = 1;
        tick(3);
        ctrl_word = mk(5, 6, 7, 8, 3, 2, 0);
        pix_word = 9'd4;
        tick(2);
        rst = 0;
        tick(80);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule